// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between two independent access ports and a shared 4K x 16 memory core. Each port presents an enable, a write strobe, a 12-bit word address and write data. The block registers those requests. When both registered requests are enabled and point at the same word, it grants the access to the port that was there first and signals busy (active low) to the other port. The losing port's write strobe is blocked before it reaches the core, so the contested word is never written by the side that was told to wait.

The block runs in one of two modes, chosen by a mode input. As master it runs its own collision arbitration and drives the busy lines. As slave it never asserts its busy outputs. Instead it takes busy indications from outside, for example from a master that watches the same addresses, and uses them to block writes. The core-side outputs carry the registered enable, address and data of each port, plus the gated write enable.

Top module: `dp_collision_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, both busy outputs are high (inactive) and both core write enables are low.
- R2: In master mode, when the registered addresses differ or either port is disabled, both busy outputs stay high.
- R3: In master mode, when the left request has held the same address for at least one cycle before the right port arrives on that address, the right busy output goes low and the left stays high.
- R4: In master mode, when the right request was settled on the address before the left port arrives, the left busy output goes low and the right stays high.
- R5: When both ports arrive at the same address in the same cycle, the left port wins (right busy low, left busy high). The two busy outputs are never low at the same time.
- R6: A write from the port whose busy is low does not reach the core (its core write enable is 0), while the winning port's write passes.
- R7: Busy stays low for the loser while the collision persists. Once the winner leaves the address, busy rises the next cycle. If the former winner comes back while the other port is still there, it arrives second and now loses.
- R8: In slave mode both busy outputs stay high regardless of address match, and a low busy input on a port forces that port's core write enable to 0.
- R9: A request driven before a clock edge appears on the core address, data and write enable outputs after exactly that one edge.
- R10: A port whose enable is low produces no core write, even with its write strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from outside |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| l_busy_in_n | input | 1 | External busy for left port, active low, used in slave mode |
| r_busy_in_n | input | 1 | External busy for right port, active low, used in slave mode |
| l_busy_n | output | 1 | Busy to left port, active low |
| r_busy_n | output | 1 | Busy to right port, active low |
| core_l_en | output | 1 | Registered left enable to core |
| core_l_we | output | 1 | Gated left write enable to core |
| core_l_addr | output | ADDR_W | Registered left address to core |
| core_l_wdata | output | DATA_W | Registered left data to core |
| core_r_en | output | 1 | Registered right enable to core |
| core_r_we | output | 1 | Gated right write enable to core |
| core_r_addr | output | ADDR_W | Registered right address to core |
| core_r_wdata | output | DATA_W | Registered right data to core |

## Verification
The bench targets arrival order. It stages one port a cycle ahead of the other in each direction, and also brings both in on the same edge. A design that ignored arrival order would flag the wrong side, and a tie without priority would flag both sides or neither. It holds a collision for several cycles, then moves the winner away and brings it back, to catch an owner register that never clears or never changes hands. It also checks that a disabled port with its strobe high writes nothing, and that slave mode ignores a real address match while still obeying busy inputs. A design that mixed up the two modes would block the wrong write.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
  localparam int N_PORTS = 2;
endpackage

// File: rtl/dpca_port_stage.sv
module dpca_port_stage #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              q_en,
  output logic              q_we,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_settled
);
  logic              p_en;
  logic [ADDR_W-1:0] p_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en    <= 1'b0;
      q_we    <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      p_en    <= 1'b0;
      p_addr  <= '0;
    end else begin
      q_en    <= en;
      q_we    <= we;
      q_addr  <= addr;
      q_wdata <= wdata;
      p_en    <= q_en;
      p_addr  <= q_addr;
    end
  end

  // Request was already present at this address one cycle earlier
  assign q_settled = q_en & p_en & (p_addr == q_addr);
endmodule

// File: rtl/dpca_arbiter.sv
module dpca_arbiter
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic              settled_l,
  input  logic              en_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic              settled_r,
  output logic              busy_l,
  output logic              busy_r
);
  owner_t owner_q;
  owner_t pick;
  logic   hit;

  assign hit = en_l & en_r & (addr_l == addr_r);

  always_comb begin
    pick = OWN_NONE;
    if (hit) begin
      if (owner_q != OWN_NONE)
        pick = owner_q;
      else if (settled_r && !settled_l)
        pick = OWN_RIGHT;
      else
        pick = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= pick;
  end

  assign busy_l = (pick == OWN_RIGHT);
  assign busy_r = (pick == OWN_LEFT);
endmodule

// File: rtl/dp_collision_arb.sv
module dp_collision_arb
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_n,
  output logic              r_busy_n,
  output logic              core_l_en,
  output logic              core_l_we,
  output logic [ADDR_W-1:0] core_l_addr,
  output logic [DATA_W-1:0] core_l_wdata,
  output logic              core_r_en,
  output logic              core_r_we,
  output logic [ADDR_W-1:0] core_r_addr,
  output logic [DATA_W-1:0] core_r_wdata
);
  logic [N_PORTS-1:0]             in_en, in_we, in_busy_ext;
  logic [N_PORTS-1:0][ADDR_W-1:0] in_addr, q_addr;
  logic [N_PORTS-1:0][DATA_W-1:0] in_wdata, q_wdata;
  logic [N_PORTS-1:0]             q_en, q_we, q_settled;
  logic [N_PORTS-1:0]             arb_busy, eff_busy, gated_we;

  assign in_en[PORT_L]       = l_en;
  assign in_en[PORT_R]       = r_en;
  assign in_we[PORT_L]       = l_we;
  assign in_we[PORT_R]       = r_we;
  assign in_addr[PORT_L]     = l_addr;
  assign in_addr[PORT_R]     = r_addr;
  assign in_wdata[PORT_L]    = l_wdata;
  assign in_wdata[PORT_R]    = r_wdata;
  assign in_busy_ext[PORT_L] = ~l_busy_in_n;
  assign in_busy_ext[PORT_R] = ~r_busy_in_n;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    dpca_port_stage #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .en       (in_en[p]),
      .we       (in_we[p]),
      .addr     (in_addr[p]),
      .wdata    (in_wdata[p]),
      .q_en     (q_en[p]),
      .q_we     (q_we[p]),
      .q_addr   (q_addr[p]),
      .q_wdata  (q_wdata[p]),
      .q_settled(q_settled[p])
    );

    assign eff_busy[p] = is_master ? arb_busy[p] : in_busy_ext[p];
    assign gated_we[p] = q_en[p] & q_we[p] & ~eff_busy[p];
  end

  dpca_arbiter #(
    .ADDR_W(ADDR_W)
  ) u_arb (
    .clk      (clk),
    .rst      (rst),
    .en_l     (q_en[PORT_L]),
    .addr_l   (q_addr[PORT_L]),
    .settled_l(q_settled[PORT_L]),
    .en_r     (q_en[PORT_R]),
    .addr_r   (q_addr[PORT_R]),
    .settled_r(q_settled[PORT_R]),
    .busy_l   (arb_busy[PORT_L]),
    .busy_r   (arb_busy[PORT_R])
  );

  assign l_busy_n     = ~(is_master & arb_busy[PORT_L]);
  assign r_busy_n     = ~(is_master & arb_busy[PORT_R]);
  assign core_l_en    = q_en[PORT_L];
  assign core_r_en    = q_en[PORT_R];
  assign core_l_we    = gated_we[PORT_L];
  assign core_r_we    = gated_we[PORT_R];
  assign core_l_addr  = q_addr[PORT_L];
  assign core_r_addr  = q_addr[PORT_R];
  assign core_l_wdata = q_wdata[PORT_L];
  assign core_r_wdata = q_wdata[PORT_R];
endmodule

// File: rtl/dp_collision_arb_chk.sv
module dp_collision_arb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              is_master,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_n,
  input logic              r_busy_n,
  input logic              core_l_en,
  input logic              core_r_en,
  input logic              core_l_we,
  input logic              core_r_we,
  input logic [ADDR_W-1:0] core_l_addr,
  input logic [ADDR_W-1:0] core_r_addr
);
  logic same_word;
  assign same_word = core_l_en & core_r_en & (core_l_addr == core_r_addr);

  AST_RESET_NO_WRITE: assert property (@(posedge clk) rst |=> (!core_l_we && !core_r_we)); // R1
  AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (is_master && !same_word) |-> (l_busy_n && r_busy_n)); // R2
  AST_NEVER_BOTH_BUSY: assert property (@(posedge clk) disable iff (rst)
    !(!l_busy_n && !r_busy_n)); // R5
  AST_MATCH_ONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (is_master && same_word) |-> $countones({l_busy_n, r_busy_n}) == 1); // R5
  AST_LOSER_NO_WRITE_L: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> !core_l_we); // R6
  AST_LOSER_NO_WRITE_R: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> !core_r_we); // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (is_master && $past(is_master) && !$past(r_busy_n) && same_word && $past(same_word)
     && $stable(core_l_addr) && $stable(core_r_addr)) |-> !r_busy_n); // R7
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !is_master |-> (l_busy_n && r_busy_n)); // R8
  AST_SLAVE_GATE: assert property (@(posedge clk) disable iff (rst)
    (!is_master && (!l_busy_in_n || !r_busy_in_n)) |->
    ((l_busy_in_n || !core_l_we) && (r_busy_in_n || !core_r_we))); // R8
  AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((!core_l_en -> !core_l_we) && (!core_r_en -> !core_r_we))); // R10
endmodule

bind dp_collision_arb dp_collision_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .is_master  (is_master),
  .l_busy_in_n(l_busy_in_n),
  .r_busy_in_n(r_busy_in_n),
  .l_busy_n   (l_busy_n),
  .r_busy_n   (r_busy_n),
  .core_l_en  (core_l_en),
  .core_r_en  (core_r_en),
  .core_l_we  (core_l_we),
  .core_r_we  (core_r_we),
  .core_l_addr(core_l_addr),
  .core_r_addr(core_r_addr)
);

// File: tb/test_dp_collision_arb.sv
module test_dp_collision_arb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1;
  logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic l_busy_n, r_busy_n, core_l_en, core_r_en, core_l_we, core_r_we;
  logic [AW-1:0] core_l_addr, core_r_addr;
  logic [DW-1:0] core_l_wdata, core_r_wdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW), .DATA_W(DW)) i_dp_collision_arb (
    .clk(clk), .rst(rst), .is_master(is_master),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .core_l_en(core_l_en), .core_l_we(core_l_we), .core_l_addr(core_l_addr),
    .core_l_wdata(core_l_wdata),
    .core_r_en(core_r_en), .core_r_we(core_r_we), .core_r_addr(core_r_addr),
    .core_r_wdata(core_r_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      summary();
    end
  end

  task automatic idle(input int n);
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    l_busy_in_n = 1; r_busy_in_n = 1;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy during reset", {l_busy_n, r_busy_n}, 2'b11);
    chk("R1 we during reset", {core_l_we, core_r_we}, 2'b00);
    l_en = 1; l_we = 1; r_en = 1; r_we = 1; l_addr = 12'h010; r_addr = 12'h010;
    @(negedge clk);
    rst = 0;
    idle(0);
    @(negedge clk);
    chk("R1 busy after reset", {l_busy_n, r_busy_n}, 2'b11);
    chk("R1 we after reset", {core_l_we, core_r_we}, 2'b00);
    idle(2);
  endtask

  task automatic t_no_match();
    l_en = 1; l_we = 1; l_addr = 12'h123; l_wdata = 16'hA5A5;
    r_en = 1; r_we = 1; r_addr = 12'h124; r_wdata = 16'h5A5A;
    @(negedge clk);
    chk("R2 busy differing addr", {l_busy_n, r_busy_n}, 2'b11);
    chk("R9 both writes pass", {core_l_we, core_r_we}, 2'b11);
    chk("R9 left addr", core_l_addr, 12'h123);
    chk("R9 left data", core_l_wdata, 16'hA5A5);
    chk("R9 right data", core_r_wdata, 16'h5A5A);
    r_en = 0; r_addr = 12'h123;
    @(negedge clk);
    chk("R2 busy one disabled", {l_busy_n, r_busy_n}, 2'b11);
    chk("R10 disabled port no write", core_r_we, 1'b0);
    idle(2);
  endtask

  task automatic t_left_first();
    l_en = 1; l_we = 1; l_addr = 12'h0FE;
    @(negedge clk);
    r_en = 1; r_we = 1; r_addr = 12'h0FE;
    @(negedge clk);
    chk("R3 right busy", {l_busy_n, r_busy_n}, 2'b10);
    chk("R6 loser write blocked", {core_l_we, core_r_we}, 2'b10);
    idle(2);
  endtask

  task automatic t_right_first();
    r_en = 1; r_we = 1; r_addr = 12'h0FF;
    @(negedge clk);
    l_en = 1; l_we = 1; l_addr = 12'h0FF;
    @(negedge clk);
    chk("R4 left busy", {l_busy_n, r_busy_n}, 2'b01);
    chk("R6 left write blocked", {core_l_we, core_r_we}, 2'b01);
    idle(2);
  endtask

  task automatic t_tie();
    l_en = 1; l_we = 1; l_addr = 12'hFFF;
    r_en = 1; r_we = 1; r_addr = 12'hFFF;
    @(negedge clk);
    chk("R5 tie left wins", {l_busy_n, r_busy_n}, 2'b10);
    @(negedge clk);
    chk("R5 tie held", {l_busy_n, r_busy_n}, 2'b10);
    idle(2);
  endtask

  task automatic t_hold();
    l_en = 1; l_addr = 12'h200;
    @(negedge clk);
    r_en = 1; r_addr = 12'h200;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R7 busy held", {l_busy_n, r_busy_n}, 2'b10);
    end
    l_addr = 12'h201;
    @(negedge clk);
    chk("R7 released after winner left", {l_busy_n, r_busy_n}, 2'b11);
    l_addr = 12'h200;
    @(negedge clk);
    chk("R7 ownership moved", {l_busy_n, r_busy_n}, 2'b01);
    idle(2);
  endtask

  task automatic t_slave();
    is_master = 0;
    l_en = 1; l_we = 1; l_addr = 12'h300;
    r_en = 1; r_we = 1; r_addr = 12'h300;
    @(negedge clk);
    chk("R8 slave busy outputs idle", {l_busy_n, r_busy_n}, 2'b11);
    chk("R8 slave writes pass", {core_l_we, core_r_we}, 2'b11);
    l_busy_in_n = 0;
    @(negedge clk);
    chk("R8 slave left inhibited", {core_l_we, core_r_we}, 2'b01);
    l_busy_in_n = 1; r_busy_in_n = 0;
    @(negedge clk);
    chk("R8 slave right inhibited", {core_l_we, core_r_we}, 2'b10);
    idle(2);
    is_master = 1;
  endtask

  initial begin
    t_reset();
    t_no_match();
    t_left_first();
    t_right_first();
    t_tie();
    t_hold();
    t_slave();
    summary();
  end
endmodule